// File: doc/BRIEF.md
# Stereo Sample Overload Detector

This block watches the stream of signed stereo samples coming out of an ADC decimator and raises a single overload flag when either channel comes close to full scale. Each sample pair arrives with a valid strobe. The magnitude of each channel is compared against a fixed threshold a little more than 1 dB under the largest representable code, which is about seven eighths of full scale. When either channel is over the threshold, the registered flag goes high.

The flag then stays high for a hold window that is counted in sample beats, not clock cycles. Any new crossing during the window reloads it, so the flag drops only after a full window of quiet samples. The input side uses a valid/ready handshake. The block never applies back-pressure: `in_ready` is held high at all times, and a beat is any clock cycle in which `in_valid` is high. Samples presented while `in_valid` is low are ignored, and clock cycles with no beat do not advance the window.

Top module: `ovl_detect`

## Requirements
- R1: The synchronous reset `rst` clears the flag and the hold count. After reset the flag is low, and it stays low through quiet beats. Asserting reset in the middle of a hold window drops the flag on the next edge.
- R2: On a beat where either channel is over the threshold, `ovl_flag` is high from the next clock edge. This holds when only the left channel is over, when only the right channel is over, and when both are over.
- R3: Samples are 24-bit two's complement. A channel is over only when its absolute value is strictly greater than 7340031, which is floor((2^23-1)*7/8). The values 7340031 and -7340031 do not trigger. The values 7340032 and -7340032 do trigger.
- R4: The most negative code, -8388608 (0x800000), saturates to a magnitude of 8388607 instead of wrapping, so it triggers.
- R5: After the last triggering beat, the flag stays high through 511 further non-triggering beats. It goes low on the edge that takes the 512th non-triggering beat.
- R6: A triggering beat during the hold window restarts the window. A full 512 non-triggering beats are then needed before the flag falls.
- R7: Cycles with `in_valid` low have no effect. Over-range samples on those cycles do not set the flag, and those cycles do not shorten the hold window.
- R8: `in_ready` is high in every cycle, including during reset.
- R9: A triggering beat that arrives exactly when the window would expire (the 512th quiet beat position) takes priority. The flag never goes low, and a fresh 512-beat window starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair valid strobe |
| in_ready | output | 1 | Always high; the block accepts every beat |
| in_left | input | 24 | Left channel sample, two's complement |
| in_right | input | 24 | Right channel sample, two's complement |
| ovl_flag | output | 1 | Registered overload flag |

## Verification
Two events can fall on the same beat: the hold count reaching its last step and a new crossing that reloads the count. To provoke this, the bench sends one crossing, then exactly 511 quiet beats, and then a second crossing on the beat that would otherwise clear the flag. The run passes only if the flag never drops on that edge, and the flag then falls exactly 512 quiet beats after the second crossing. A separate run places idle cycles in the middle of a window to show that expiry is counted only in beats.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  localparam int NUM_CH = 2;

  // Threshold = floor((largest positive code) * num / 2^shift)
  function automatic longint ovl_thresh(input int width, input int num, input int shift);
    longint full;
    full = (longint'(1) <<< (width - 1)) - 1;
    return (full * num) >>> shift;
  endfunction

endpackage

// File: rtl/ovl_chan_detect.sv
module ovl_chan_detect #(
  parameter int              W      = 24,
  parameter logic [W-1:0]    THRESH = '0
) (
  input  logic [W-1:0] smp,
  output logic         over
);

  localparam logic [W-1:0] MIN_CODE = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS  = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] mag;

  // absolute value; the most negative code clamps to the largest positive code
  always_comb begin
    if (smp == MIN_CODE)
      mag = MAX_POS;
    else if (smp[W-1])
      mag = (~smp) + 1'b1;
    else
      mag = smp;
  end

  assign over = (mag > THRESH);

  // saturated magnitude never has its sign bit set (R4)
  always_comb begin
    p_mag_pos_r4: assert (mag[W-1] == 1'b0);
  end

endmodule

// File: rtl/ovl_hold_timer.sv
module ovl_hold_timer #(
  parameter int HOLD = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  input  logic hit,
  output logic flag
);

  localparam int             CW   = $clog2(HOLD + 1);
  localparam logic [CW-1:0]  LOAD = CW'(HOLD);
  localparam logic [CW-1:0]  ONE  = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (beat) begin
      if (hit) begin
        cnt  <= LOAD;
        flag <= 1'b1;
      end else if (cnt != '0) begin
        cnt  <= cnt - ONE;
        flag <= (cnt != ONE);
      end
    end
  end

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (beat && hit) |=> (cnt == LOAD && flag));

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (beat && !hit && cnt != '0) |=> (cnt == $past(cnt) - ONE));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!beat) |=> ($stable(cnt) && $stable(flag)));

  p_flag_cnt_r5: assert property (@(posedge clk) disable iff (rst)
    flag == (cnt != '0));

  p_rst_r1: assert property (@(posedge clk)
    $past(rst) |-> (!flag && cnt == '0));

endmodule

// File: rtl/ovl_detect.sv
module ovl_detect #(
  parameter int SAMPLE_W   = 24,
  parameter int HOLD_BEATS = 512,
  parameter int THR_NUM    = 7,
  parameter int THR_SHIFT  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                ovl_flag
);

  import ovl_pkg::*;

  localparam longint             THR_L  = ovl_thresh(SAMPLE_W, THR_NUM, THR_SHIFT);
  localparam logic [SAMPLE_W-1:0] THRESH = SAMPLE_W'(THR_L);

  logic [SAMPLE_W-1:0] smp_arr [NUM_CH];
  logic [NUM_CH-1:0]   over_vec;
  logic                hit;
  logic                beat;

  assign smp_arr[0] = in_left;
  assign smp_arr[1] = in_right;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      ovl_chan_detect #(
        .W      (SAMPLE_W),
        .THRESH (THRESH)
      ) u_det (
        .smp  (smp_arr[ch]),
        .over (over_vec[ch])
      );
    end
  endgenerate

  assign in_ready = 1'b1;
  assign beat     = in_valid & in_ready;
  assign hit      = |over_vec;

  ovl_hold_timer #(
    .HOLD (HOLD_BEATS)
  ) u_hold (
    .clk  (clk),
    .rst  (rst),
    .beat (beat),
    .hit  (hit),
    .flag (ovl_flag)
  );

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit) |=> ovl_flag);

  p_novalid_r7: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !ovl_flag) |=> !ovl_flag);

endmodule

// File: tb/sim_ovl_detect.sv
module sim_ovl_detect;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_left = '0;
  logic [23:0] in_right = '0;
  logic        ovl_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ovl_detect u0 (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_left  (in_left),
    .in_right (in_right),
    .ovl_flag (ovl_flag)
  );

  localparam int NV = 10;
  // left, right, expected flag after one beat from reset
  localparam logic [23:0] VL [NV] = '{24'h000000, 24'h6FFFFF, 24'h700000, 24'h000000, 24'h900001,
                                      24'h900000, 24'h000000, 24'h7FFFFF, 24'hFFFFFF, 24'h800000};
  localparam logic [23:0] VR [NV] = '{24'h000000, 24'h000000, 24'h000000, 24'h700000, 24'h6FFFFF,
                                      24'h000000, 24'h800000, 24'h7FFFFF, 24'h100000, 24'h800000};
  localparam bit          VE [NV] = '{0, 0, 1, 1, 0, 1, 1, 1, 0, 1};
  // requirement for each row: R1 R3 R3 R2 R3 R3 R4 R2 R3 R4
  localparam string       VT [NV] = '{"R1", "R3", "R3", "R2", "R3", "R3", "R4", "R2", "R3", "R4"};

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input bit v, input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    in_valid = v;
    in_left  = l;
    in_right = r;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 24'h000100, 24'hFFFF00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    check(ovl_flag, 1'b0, "R1 reset flag");
    check(in_ready, 1'b1, "R8 ready after reset");

    // table walk: reset, one beat, judge flag
    for (int k = 0; k < NV; k++) begin
      do_reset();
      step(1'b1, VL[k], VR[k]);
      check(ovl_flag, VE[k], VT[k]);
    end

    // R7: over-range samples without valid are ignored
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b0, 24'h7FFFFF, 24'h800000);
    check(ovl_flag, 1'b0, "R7 no valid no set");

    // R5: exact hold length
    do_reset();
    step(1'b1, 24'h7FFFFF, 24'h0);
    quiet(511);
    check(ovl_flag, 1'b1, "R5 high after 511 quiet");
    quiet(1);
    check(ovl_flag, 1'b0, "R5 low after 512 quiet");

    // R7: idle cycles do not age the window
    do_reset();
    step(1'b1, 24'h0, 24'h800000);
    quiet(510);
    for (int i = 0; i < 50; i++) step(1'b0, 24'h0, 24'h0);
    check(ovl_flag, 1'b1, "R7 idle keeps hold");
    quiet(1);
    check(ovl_flag, 1'b1, "R7 511th quiet");
    quiet(1);
    check(ovl_flag, 1'b0, "R7 512th quiet");

    // R6: retrigger mid-window
    do_reset();
    step(1'b1, 24'h700000, 24'h0);
    quiet(300);
    step(1'b1, 24'h0, 24'h900000);
    quiet(511);
    check(ovl_flag, 1'b1, "R6 held after retrigger");
    quiet(1);
    check(ovl_flag, 1'b0, "R6 clears 512 after retrigger");

    // R9: crossing on the expiry beat
    do_reset();
    step(1'b1, 24'h7FFFFF, 24'h0);
    quiet(511);
    step(1'b1, 24'h800000, 24'h0);
    check(ovl_flag, 1'b1, "R9 no drop on expiry beat");
    quiet(511);
    check(ovl_flag, 1'b1, "R9 new window held");
    quiet(1);
    check(ovl_flag, 1'b0, "R9 new window ends");

    // R1: reset during hold, R8 ready during reset
    step(1'b1, 24'h7FFFFF, 24'h7FFFFF);
    check(ovl_flag, 1'b1, "R2 both channels");
    @(negedge clk);
    rst = 1'b1;
    #1;
    check(in_ready, 1'b1, "R8 ready in reset");
    @(posedge clk);
    #1;
    rst = 1'b0;
    check(ovl_flag, 1'b0, "R1 reset mid hold");
    quiet(3);
    check(ovl_flag, 1'b0, "R1 quiet after reset");

    finish_run();
  end

endmodule